// File: doc/BRIEF.md
# Run-Time Selectable Sixth-Order CIC Decimator

This block is the first decimation stage behind a multi-bit delta-sigma modulator. Each clock brings one sample from the modulator as 31 comparator lines. The block counts the asserted lines to get a code from 0 to 31 and re-centres it to a signed value from -16 to +15. A ratio-dependent left shift scales that value before it enters a cascade of six integrators. The integrator result is taken once every R clocks and passed through six unity-weight comb stages. The output is a 30-bit two's-complement sample with a one-cycle valid strobe at the reduced rate.

The ratio R is 4, 8 or 16 and is chosen at run time. Every stage is 30 bits wide, the width needed at R = 16. The input shift (12, 6 or 0 bits) moves the useful result to the top of the word at every ratio, so the DC gain is the same in every mode and the unused low bits stay at zero. When the ratio select changes, or on reset, all filter state is cleared. The output stays quiet until the comb delay lines hold only new data.

Top module: `cic_decim`

## Requirements
- R1: With c lines asserted (0 to 31) held constant, every settled flagged output equals (c - 16) * 2^24 at every ratio.
- R2: ratio_sel 0 selects R = 4, 1 selects R = 8, and 2 or 3 select R = 16. In steady state, out_valid pulses for one cycle exactly every R clocks.
- R3: Integrators and combs wrap modulo 2^30 with no saturation. Results stay exact at the extreme codes 0 and 31, and every flagged output lies within [-2^28, 15 * 2^24].
- R4: While rst is high, out_valid and out_data are zero. The last rising edge with rst high is a flush edge, and out_valid first goes high on the (7R+7)-th rising edge after it.
- R5: A rising edge on which ratio_sel differs from its value at the previous edge is a flush edge. It clears all filter state and drops out_valid on that edge. The first flagged output comes on the (7R+7)-th edge after it and carries the exact DC value of the new input, with no trace of the old stream.
- R6: The binary value is the count of asserted lines regardless of their positions, so non-contiguous (bubbled) line patterns give the same result as contiguous ones with the same count.
- R7: out_data changes only on an edge where out_valid goes high, and holds its value otherwise.
- R8: After a step in the input code from a to b, every flagged output lies between (a-16)*2^24 and (b-16)*2^24 inclusive. From the 12th flagged output after the step onward, the output equals (b-16)*2^24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator-rate clock; one input sample per cycle |
| rst | input | 1 | Synchronous active-high reset |
| ratio_sel | input | 2 | Decimation ratio select (0: 4, 1: 8, 2 or 3: 16) |
| therm_in | input | 31 | Comparator lines from the modulator, one sample per clock |
| out_valid | output | 1 | One-cycle strobe marking a new decimated sample |
| out_data | output | 30 | Decimated sample, two's complement |

## Verification
For each ratio, the input sweeps all 32 codes in a scrambled order. The large code-to-code steps test the exact DC gain, which shows whether the shift matches the ratio. They also test whether the transitions stay inside the convex bounds, which would expose a wrong sign, a wrong comb delay or a dropped integrator. Bubbled line patterns are rotated copies of contiguous ones with the same count, so they separate true line counting from a thermometer edge detector. Reset and each ratio change are followed by an exact count of cycles to the first strobe and a check of its value, which catches missing or partial flushes and a wrong output-suppression count.

// File: rtl/cic_pkg.sv
`timescale 1ns/1ps
package cic_pkg;

    localparam int CIC_ORDER  = 6;
    localparam int CIC_LINES  = 31;
    localparam int CIC_CODE_W = $clog2(CIC_LINES + 1);
    localparam int CIC_ACC_W  = 30;
    localparam int CIC_CNT_W  = 4;

    typedef enum logic [1:0] {
        SEL_R4      = 2'd0,
        SEL_R8      = 2'd1,
        SEL_R16     = 2'd2,
        SEL_R16_ALT = 2'd3
    } ratio_sel_e;

    // Tag that travels with each decimated sample through the comb pipeline
    typedef struct packed {
        logic vld;
        logic keep;
    } smp_tag_t;

    function automatic int unsigned ratio_log2(input logic [1:0] sel);
        case (ratio_sel_e'(sel))
            SEL_R4:  return 2;
            SEL_R8:  return 3;
            default: return 4;
        endcase
    endfunction

    // Left shift that fills the word: acc_w - (code_w + order*log2(R) + 1)
    function automatic int unsigned pre_shift(input logic [1:0] sel, input int unsigned order,
                                              input int unsigned acc_w, input int unsigned code_w);
        return acc_w - code_w - order * ratio_log2(sel) - 1;
    endfunction

endpackage

// File: rtl/cic_front.sv
`timescale 1ns/1ps
module cic_front
    import cic_pkg::*;
#(
    parameter int LINES  = CIC_LINES,
    parameter int CODE_W = CIC_CODE_W,
    parameter int ACC_W  = CIC_ACC_W,
    parameter int ORDER  = CIC_ORDER
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [1:0]       mode,
    input  logic [LINES-1:0] therm,
    output logic [ACC_W-1:0] x_q
);
    localparam int SH_W = $clog2(ACC_W);

    logic [CODE_W-1:0] ones;
    logic [CODE_W-1:0] centred;
    logic [ACC_W-1:0]  ext;
    logic [SH_W-1:0]   shamt;

    // Position-independent line count tolerates bubbles (R6)
    always_comb begin
        ones = '0;
        for (int i = 0; i < LINES; i++) begin
            ones = ones + CODE_W'(therm[i]);
        end
    end

    // Offset binary to two's complement: invert the top bit
    assign centred = {~ones[CODE_W-1], ones[CODE_W-2:0]};
    assign ext     = {{(ACC_W-CODE_W){centred[CODE_W-1]}}, centred};
    assign shamt   = SH_W'(pre_shift(mode, ORDER, ACC_W, CODE_W));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            x_q <= '0;
        end else begin
            x_q <= ext << shamt;
        end
    end
endmodule

// File: rtl/cic_integ_chain.sv
`timescale 1ns/1ps
module cic_integ_chain
    import cic_pkg::*;
#(
    parameter int ORDER = CIC_ORDER,
    parameter int ACC_W = CIC_ACC_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [ACC_W-1:0] x,
    output logic [ACC_W-1:0] y
);
    logic [ACC_W-1:0] acc [ORDER];

    for (genvar k = 0; k < ORDER; k++) begin : g_stage
        logic [ACC_W-1:0] feed;
        if (k == 0) begin : g_first
            assign feed = x;
        end else begin : g_next
            assign feed = acc[k-1];
        end
        // Modulo-2^ACC_W accumulation, no saturation
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                acc[k] <= '0;
            end else begin
                acc[k] <= acc[k] + feed;
            end
        end
    end

    assign y = acc[ORDER-1];
endmodule

// File: rtl/cic_rate_ctl.sv
`timescale 1ns/1ps
module cic_rate_ctl
    import cic_pkg::*;
#(
    parameter int ORDER = CIC_ORDER,
    parameter int CNT_W = CIC_CNT_W
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic [1:0] mode,
    output logic       take,
    output logic       keep
);
    localparam int SKIP_W = $clog2(ORDER + 1);

    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  lim;
    logic [SKIP_W-1:0] skip;

    assign lim  = CNT_W'((1 << ratio_log2(mode)) - 1);
    assign take = (cnt == lim);
    // Only samples whose comb window holds post-flush data only are kept
    assign keep = (skip == SKIP_W'(ORDER));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt  <= '0;
            skip <= '0;
        end else begin
            cnt <= take ? '0 : cnt + 1'b1;
            if (take && !keep) begin
                skip <= skip + 1'b1;
            end
        end
    end
endmodule

// File: rtl/cic_comb_chain.sv
`timescale 1ns/1ps
module cic_comb_chain
    import cic_pkg::*;
#(
    parameter int ORDER = CIC_ORDER,
    parameter int ACC_W = CIC_ACC_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  smp_tag_t         tag_in,
    input  logic [ACC_W-1:0] d_in,
    output smp_tag_t         tag_out,
    output logic [ACC_W-1:0] d_out
);
    smp_tag_t         tag [ORDER+1];
    logic [ACC_W-1:0] dat [ORDER+1];

    assign tag[0] = tag_in;
    assign dat[0] = d_in;

    // One register per stage at full clock rate: latency ORDER clocks
    for (genvar k = 0; k < ORDER; k++) begin : g_stage
        logic [ACC_W-1:0] dly;
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                dly        <= '0;
                dat[k+1]   <= '0;
                tag[k+1]   <= '0;
            end else begin
                tag[k+1].vld  <= tag[k].vld;
                tag[k+1].keep <= tag[k].keep;
                if (tag[k].vld) begin
                    dat[k+1] <= dat[k] - dly;
                    dly      <= dat[k];
                end
            end
        end
    end

    assign tag_out = tag[ORDER];
    assign d_out   = dat[ORDER];
endmodule

// File: rtl/cic_decim.sv
`timescale 1ns/1ps
module cic_decim
    import cic_pkg::*;
#(
    parameter int ORDER  = CIC_ORDER,
    parameter int LINES  = CIC_LINES,
    parameter int ACC_W  = CIC_ACC_W,
    parameter int CNT_W  = CIC_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       ratio_sel,
    input  logic [LINES-1:0] therm_in,
    output logic             out_valid,
    output logic [ACC_W-1:0] out_data
);
    localparam int CODE_W = $clog2(LINES + 1);

    logic [1:0]       mode_q;
    logic             flush;
    logic [ACC_W-1:0] x0;
    logic [ACC_W-1:0] integ_y;
    logic             take;
    logic             keep;
    smp_tag_t         s_tag;
    logic [ACC_W-1:0] s_dat;
    smp_tag_t         c_tag;
    logic [ACC_W-1:0] c_dat;

    assign flush = (ratio_sel != mode_q);

    always_ff @(posedge clk) begin
        mode_q <= ratio_sel;
    end

    cic_front #(
        .LINES (LINES),
        .CODE_W(CODE_W),
        .ACC_W (ACC_W),
        .ORDER (ORDER)
    ) u_front (
        .clk  (clk),
        .rst  (rst),
        .clr  (flush),
        .mode (mode_q),
        .therm(therm_in),
        .x_q  (x0)
    );

    cic_integ_chain #(
        .ORDER(ORDER),
        .ACC_W(ACC_W)
    ) u_integ (
        .clk(clk),
        .rst(rst),
        .clr(flush),
        .x  (x0),
        .y  (integ_y)
    );

    cic_rate_ctl #(
        .ORDER(ORDER),
        .CNT_W(CNT_W)
    ) u_rate (
        .clk (clk),
        .rst (rst),
        .clr (flush),
        .mode(mode_q),
        .take(take),
        .keep(keep)
    );

    // Rate reduction: capture the integrator output once per R clocks
    always_ff @(posedge clk) begin
        if (rst || flush) begin
            s_tag <= '0;
            s_dat <= '0;
        end else begin
            s_tag.vld  <= take;
            s_tag.keep <= keep;
            if (take) begin
                s_dat <= integ_y;
            end
        end
    end

    cic_comb_chain #(
        .ORDER(ORDER),
        .ACC_W(ACC_W)
    ) u_comb (
        .clk    (clk),
        .rst    (rst),
        .clr    (flush),
        .tag_in (s_tag),
        .d_in   (s_dat),
        .tag_out(c_tag),
        .d_out  (c_dat)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (flush) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= c_tag.vld && c_tag.keep;
            if (c_tag.vld && c_tag.keep) begin
                out_data <= c_dat;
            end
        end
    end
endmodule

// File: rtl/cic_decim_chk.sv
`timescale 1ns/1ps
module cic_decim_chk
    import cic_pkg::*;
#(
    parameter int ACC_W = CIC_ACC_W
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       ratio_sel,
    input logic             out_valid,
    input logic [ACC_W-1:0] out_data
);
    logic [1:0] sel_q;
    logic       flush_c;
    logic [7:0] since;
    logic [7:0] gap;
    logic       seen;
    logic [7:0] r_len;

    assign flush_c = rst || (ratio_sel != sel_q);
    assign r_len   = 8'(1 << ratio_log2(sel_q));

    always_ff @(posedge clk) begin
        sel_q <= ratio_sel;
        if (flush_c) begin
            since <= '0;
            gap   <= '0;
            seen  <= 1'b0;
        end else begin
            if (since != 8'hFF) since <= since + 1'b1;
            if (out_valid) begin
                seen <= 1'b1;
                gap  <= 8'd1;
            end else if (gap != 8'hFF) begin
                gap <= gap + 1'b1;
            end
        end
    end

    // R4/R5: no strobe before the comb window is refilled
    a_r4_first_valid: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (since >= 8'(7 * r_len + 7)));

    a_r4_reset_quiet: assert property (@(posedge clk)
        rst |=> !out_valid);

    a_r5_flush_quiet: assert property (@(posedge clk) disable iff (rst)
        (ratio_sel != sel_q) |=> !out_valid);

    // R2: strobes spaced by the selected ratio
    a_r2_spacing: assert property (@(posedge clk) disable iff (rst)
        (out_valid && seen && !flush_c) |-> (gap == r_len));

    // R7: data moves only with a strobe
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        !$stable(out_data) |-> out_valid);

    // R3: flagged outputs inside the scaled input range
    a_r3_range: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (($signed(out_data) >= -(32'sd1 <<< 28)) &&
                       ($signed(out_data) <= (32'sd15 <<< 24))));
endmodule

bind cic_decim cic_decim_chk #(.ACC_W(ACC_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ratio_sel(ratio_sel),
    .out_valid(out_valid),
    .out_data (out_data)
);

// File: tb/cic_decim_tb.sv
`timescale 1ns/1ps
module cic_decim_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  sel = 2'd0;
    logic [30:0] therm = '0;
    logic        out_valid;
    logic [29:0] out_data;

    int checks = 0;
    int fails  = 0;
    int hold_err = 0;
    logic [29:0] last_data = '0;

    always #10 clk = ~clk;   // 50 MHz

    cic_decim u_dut (
        .clk      (clk),
        .rst      (rst),
        .ratio_sel(sel),
        .therm_in (therm),
        .out_valid(out_valid),
        .out_data (out_data)
    );

    function automatic logic [30:0] pat(input int k, input int rot);
        logic [30:0] base;
        logic [61:0] d;
        base = (k == 0) ? 31'd0 : 31'((64'd1 << k) - 1);
        d = {base, base} << rot;
        return d[61:31];
    endfunction

    function automatic longint dc(input int code);
        return (longint'(code) - 16) * 64'sd16777216;
    endfunction

    function automatic int rof(input int s);
        return (s == 0) ? 4 : (s == 1) ? 8 : 16;
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick_watch();
        @(negedge clk);
        if (!out_valid && out_data !== last_data) hold_err++;
        last_data = out_data;
    endtask

    task automatic next_valid(output longint v, output int n);
        n = 0;
        do begin
            tick_watch();
            n++;
        end while (!out_valid && n < 400);
        if (!out_valid) chk(1'b0, "strobe timeout", n, 0);
        v = longint'($signed(out_data));
    endtask

    task automatic sweep(input int s, inout int prev);
        int r, sp_err, bd_err, n;
        longint v, lo, hi;
        r = rof(s);
        sp_err = 0; bd_err = 0; hold_err = 0;
        for (int j = 0; j < 32; j++) begin
            int code;
            code = (j * 13 + 5) % 32;
            therm = pat(code, 0);
            lo = (dc(prev) < dc(code)) ? dc(prev) : dc(code);
            hi = (dc(prev) < dc(code)) ? dc(code) : dc(prev);
            for (int m = 1; m <= 12; m++) begin
                next_valid(v, n);
                if (n != r) sp_err++;
                if (v < lo || v > hi) bd_err++;
            end
            if (code == 0 || code == 31)
                chk(v == dc(code), "R3 extreme code exact", v, dc(code));
            else
                chk(v == dc(code), "R1/R8 settled DC value", v, dc(code));
            prev = code;
        end
        chk(sp_err == 0, "R2 strobe spacing errors", sp_err, 0);
        chk(bd_err == 0, "R8 step bound errors", bd_err, 0);
        chk(hold_err == 0, "R7 data moved without strobe", hold_err, 0);
    endtask

    task automatic mode_change(input int s, input int code, inout int prev);
        int n;
        longint v;
        sel = 2'(s);
        therm = pat(code, 0);
        next_valid(v, n);
        chk(n == 7 * rof(s) + 8, "R5 first strobe after ratio change", n, 7 * rof(s) + 8);
        chk(v == dc(code), "R5 first value after ratio change", v, dc(code));
        prev = code;
    endtask

    initial begin : watchdog
        #4000000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        int n, prev;
        longint v;
        therm = pat(20, 0);
        sel = 2'd0;
        rst = 1'b1;
        repeat (5) @(negedge clk);
        chk(out_valid == 1'b0, "R4 reset valid", out_valid, 0);
        chk(out_data == '0, "R4 reset data", out_data, 0);
        last_data = out_data;
        rst = 1'b0;
        next_valid(v, n);
        chk(n == 35, "R4 first strobe after reset", n, 35);
        chk(v == dc(20), "R4 first value after reset", v, dc(20));
        prev = 20;

        sweep(0, prev);

        // R6: rotated (bubbled) patterns with the same count
        for (int b = 0; b < 4; b++) begin
            int codes[4] = '{3, 16, 27, 31};
            int rots[4]  = '{5, 11, 19, 30};
            therm = pat(codes[b], rots[b]);
            for (int m = 0; m < 12; m++) next_valid(v, n);
            chk(v == dc(codes[b]), "R6 bubbled pattern", v, dc(codes[b]));
            prev = codes[b];
        end

        mode_change(1, 9, prev);
        sweep(1, prev);
        mode_change(2, 30, prev);
        sweep(2, prev);
        mode_change(3, 1, prev);   // R2: select 3 runs at R = 16
        sweep(3, prev);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule